// File: doc/BRIEF.md
# Virtual Partition ID Translator

This block converts a virtual partition identifier, presented with a lookup strobe, into a physical partition identifier. The conversion uses a small table of 64-bit mapping registers that software fills. Each register carries four 16-bit physical identifiers, so register k, lane j (bits [16*j+15:16*j]) serves virtual identifier 4*k+j. The parameter `MAX_REG_IDX` (0 to 7) sets the highest register that exists, which gives 4*(MAX_REG_IDX+1) translatable identifiers. A 32-bit valid vector marks which entries may be used.

Translation is gated per requester. A kernel-context lookup obeys one enable and a user-context lookup obeys another. A global hypervisor enable overrides both. When translation is off, the identifier passes through unchanged. When translation is on but the entry is unusable, the block returns 0 and a one-cycle invalid flag. Results are registered and appear one clock after the request. A write to a register that does not exist leaves the table alone and returns an error pulse.

Top module: `vpid_xlate`

## Requirements
- R1: After reset and until the first request or write, rsp_valid, rsp_invalid and wr_err are all 0.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with req=1, and 0 otherwise.
- R3: With translation on, an in-range virtual identifier v whose valid bit map_valid[v] is 1 returns bits [16*(v%4)+15 : 16*(v%4)] of register v/4, with rsp_invalid=0.
- R4: With translation on and v in range, map_valid[v]=0 returns rsp_pid=0 and rsp_invalid=1.
- R5: With translation on, any v >= 4*(MAX_REG_IDX+1) returns rsp_pid=0 and rsp_invalid=1, whatever the valid vector holds.
- R6: req_ctx=1 (kernel) is translated only when kern_en=1, and req_ctx=0 (user) only when user_en=1. An untranslated request returns rsp_pid=req_vid with rsp_invalid=0.
- R7: With hyp_en=0, every request returns rsp_pid=req_vid with rsp_invalid=0, whatever the context enables hold.
- R8: A write in the same cycle as a lookup of the same register does not affect that lookup. It affects the next one.
- R9: A write with wr_idx > MAX_REG_IDX changes no implemented register and raises wr_err for one cycle, the cycle after the write. Writes to implemented indices leave wr_err at 0.
- R10: rsp_invalid is 1 only in a cycle where rsp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the outputs |
| hyp_en | input | 1 | Global translation enable; 0 forces pass-through |
| kern_en | input | 1 | Translation enable for kernel-context requests |
| user_en | input | 1 | Translation enable for user-context requests |
| map_valid | input | 32 | Bit n marks entry n usable |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 64 | Four packed 16-bit entries, lane 0 in the low bits |
| req | input | 1 | Lookup strobe |
| req_ctx | input | 1 | Requester context: 1 kernel, 0 user |
| req_vid | input | 16 | Virtual identifier to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after req |
| rsp_pid | output | 16 | Physical identifier result |
| rsp_invalid | output | 1 | Result came from an unusable or out-of-range entry |
| wr_err | output | 1 | Pulse after a write to a nonexistent register |

## Verification
The assertions assume the control inputs are stable for the whole cycle in which req is sampled. They also assume that no lookup of an entry is made before that entry has been written, because the table has no defined value after reset. The stimulus changes inputs only on the falling clock edge. It writes every implemented register before the first lookup, and it rewrites registers only through the same write port. Indices above the implemented range are used only to exercise the error path.

// File: rtl/vpid_xlate.sv
module vpid_xlate #(
  parameter int MAX_REG_IDX = 5,
  parameter int ID_W        = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hyp_en,
  input  logic                kern_en,
  input  logic                user_en,
  input  logic [31:0]         map_valid,
  input  logic                wr_en,
  input  logic [2:0]          wr_idx,
  input  logic [4*ID_W-1:0]   wr_data,
  input  logic                req,
  input  logic                req_ctx,
  input  logic [ID_W-1:0]     req_vid,
  output logic                rsp_valid,
  output logic [ID_W-1:0]     rsp_pid,
  output logic                rsp_invalid,
  output logic                wr_err
);
  localparam int LANES    = 4;
  localparam int NUM_REGS = MAX_REG_IDX + 1;
  localparam int NUM_IDS  = LANES * NUM_REGS;
  localparam int REG_W    = LANES * ID_W;
  localparam int SEL_W    = $clog2(NUM_IDS);

  logic [REG_W-1:0] map_q [NUM_REGS];
  logic [ID_W-1:0]  hit_pid;

  wire             xl_on    = hyp_en && (req_ctx ? kern_en : user_en);
  wire             in_range = req_vid < ID_W'(NUM_IDS);
  wire [SEL_W-1:0] sel      = req_vid[SEL_W-1:0];
  wire             usable   = in_range && map_valid[sel];
  wire             wr_ok    = wr_idx <= 3'(MAX_REG_IDX);

  always_comb begin
    hit_pid = '0;
    for (int k = 0; k < NUM_REGS; k++)
      for (int j = 0; j < LANES; j++)
        if (int'(sel) == k * LANES + j) hit_pid = map_q[k][j*ID_W +: ID_W];
  end

  always_ff @(posedge clk)
    for (int k = 0; k < NUM_REGS; k++)
      if (wr_en && wr_ok && int'(wr_idx) == k) map_q[k] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_invalid <= 1'b0;
      rsp_pid     <= '0;
      wr_err      <= 1'b0;
    end else begin
      rsp_valid   <= req;
      rsp_invalid <= req && xl_on && !usable;
      wr_err      <= wr_en && !wr_ok;
      if (req) rsp_pid <= !xl_on ? req_vid : (usable ? hit_pid : '0);
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);
  assert_inv_only_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_invalid |-> rsp_valid);
  assert_inv_gives_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_invalid |-> rsp_pid == '0);
  assert_passthru_hyp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hyp_en) |=> (rsp_pid == $past(req_vid) && !rsp_invalid));
  assert_out_of_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hyp_en && (req_ctx ? kern_en : user_en) && req_vid >= ID_W'(NUM_IDS)) |=> rsp_invalid);
  assert_wr_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > 3'(MAX_REG_IDX)) |=> wr_err);
  assert_wr_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx > 3'(MAX_REG_IDX)) |=> !wr_err);
endmodule

// File: tb/vpid_xlate_tb.sv
module vpid_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 5;
  localparam int NIDS = 4 * (MAXR + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hyp_en = 1'b1, kern_en = 1'b1, user_en = 1'b1;
  logic [31:0] map_valid = 32'hFFFF_FFFF;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        req = 1'b0, req_ctx = 1'b0;
  logic [15:0] req_vid = '0;
  logic        rsp_valid, rsp_invalid, wr_err;
  logic [15:0] rsp_pid;

  int compared = 0, mismatched = 0;

  vpid_xlate #(.MAX_REG_IDX(MAXR), .ID_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .hyp_en(hyp_en), .kern_en(kern_en), .user_en(user_en),
    .map_valid(map_valid), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req(req), .req_ctx(req_ctx), .req_vid(req_vid),
    .rsp_valid(rsp_valid), .rsp_pid(rsp_pid), .rsp_invalid(rsp_invalid), .wr_err(wr_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] tbl [0:7];
  logic        e_v = 1'b0, e_inv = 1'b0, e_err = 1'b0;
  logic [15:0] e_pid = '0;
  string       e_tag = "R1";
  logic        in_reset = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_v = 1'b0; e_inv = 1'b0; e_err = 1'b0; in_reset = 1'b1;
    end else begin
      in_reset = 1'b0;
      e_v   = req;
      e_err = wr_en && (int'(wr_idx) > MAXR);
      e_inv = 1'b0;
      if (req) begin
        int  v;
        logic on;
        v  = int'(req_vid);
        on = hyp_en && (req_ctx ? kern_en : user_en);
        if (!on) begin
          e_pid = req_vid; e_tag = hyp_en ? "R6" : "R7";
        end else if (v >= NIDS) begin
          e_pid = 16'h0; e_inv = 1'b1; e_tag = "R5";
        end else if (!map_valid[v]) begin
          e_pid = 16'h0; e_inv = 1'b1; e_tag = "R4";
        end else begin
          e_pid = tbl[v/4][16*(v%4) +: 16]; e_tag = "R3";
        end
      end
      if (wr_en && int'(wr_idx) <= MAXR) tbl[wr_idx] = wr_data;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (in_reset) begin
      chk("R1 rsp_valid", 16'(rsp_valid), 16'h0);
      chk("R1 rsp_invalid", 16'(rsp_invalid), 16'h0);
      chk("R1 wr_err", 16'(wr_err), 16'h0);
    end else begin
      chk("R2 rsp_valid", 16'(rsp_valid), 16'(e_v));
      chk("R9 wr_err", 16'(wr_err), 16'(e_err));
      if (e_v) begin
        chk({e_tag, " rsp_pid"}, rsp_pid, e_pid);
        chk({e_tag, " rsp_invalid"}, 16'(rsp_invalid), 16'(e_inv));
      end else begin
        chk("R10 rsp_invalid idle", 16'(rsp_invalid), 16'h0);
      end
    end
  end

  task automatic step(input logic r, input logic c, input logic [15:0] v,
                      input logic w, input logic [2:0] wi, input logic [63:0] wd);
    @(negedge clk);
    req = r; req_ctx = c; req_vid = v; wr_en = w; wr_idx = wi; wr_data = wd;
  endtask

  task automatic look(input logic c, input logic [15:0] v);
    step(1'b1, c, v, 1'b0, 3'd0, 64'h0);
  endtask

  task automatic wr(input logic [2:0] wi, input logic [63:0] wd);
    step(1'b0, 1'b0, 16'h0, 1'b1, wi, wd);
  endtask

  function automatic logic [63:0] pat(input int k, input int s);
    return {16'(s + k*4 + 3), 16'(s + k*4 + 2), 16'(s + k*4 + 1), 16'(s + k*4)};
  endfunction

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 64'h0);
    // R1 checked during reset; fill table
    for (int k = 0; k <= MAXR; k++) wr(3'(k), pat(k, 16'h1100));
    // R3 every in-range id in both contexts, R5 beyond range
    for (int v = 0; v < 32; v++) look(1'b1, 16'(v));
    for (int v = 0; v < 32; v++) look(1'b0, 16'(v));
    look(1'b1, 16'd40); look(1'b0, 16'hFFFF);
    // R4 sparse valid vector
    step(1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 64'h0);
    map_valid = 32'hA5C3_0F69;
    for (int v = 0; v < 32; v++) look(v[0], 16'(v));
    map_valid = 32'hFFFF_FFFF;
    // R6 context enables
    kern_en = 1'b0; user_en = 1'b1;
    look(1'b1, 16'd5); look(1'b0, 16'd5); look(1'b1, 16'd300);
    kern_en = 1'b1; user_en = 1'b0;
    look(1'b1, 16'd6); look(1'b0, 16'd6); look(1'b0, 16'd30);
    kern_en = 1'b1; user_en = 1'b1;
    // R7 hypervisor off
    hyp_en = 1'b0;
    look(1'b1, 16'd7); look(1'b0, 16'hBEEF); look(1'b1, 16'd23);
    hyp_en = 1'b1;
    // R8 write and lookup of register 3 in the same cycle
    step(1'b1, 1'b1, 16'd13, 1'b1, 3'd3, pat(3, 16'h7700));
    look(1'b1, 16'd13); look(1'b0, 16'd12); look(1'b0, 16'd15);
    // R9 writes to nonexistent registers, then confirm table intact
    wr(3'd6, 64'hDEAD_DEAD_DEAD_DEAD);
    wr(3'd7, 64'hBAD0_BAD1_BAD2_BAD3);
    step(1'b1, 1'b0, 16'd0, 1'b1, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int v = 0; v < NIDS; v++) look(1'b1, 16'(v));
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      hyp_en  = ($urandom % 8) != 0;
      kern_en = ($urandom % 4) != 0;
      user_en = ($urandom % 4) != 0;
      map_valid = $urandom;
      step(1'($urandom), 1'($urandom), 16'($urandom % 36), 1'($urandom % 3 == 0),
           3'($urandom), {$urandom, $urandom});
    end
    step(1'b0, 1'b0, 16'h0, 1'b0, 3'd0, 64'h0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule